// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block is a blocking data cache placed between a processor-side word port and a slower main-memory port that moves whole lines. The address is cut into a tag, a set index and a word/byte offset. Each set holds two ways. Every way keeps a valid flag, a dirty flag, a tag and a line of data, and each set keeps one recency bit. Both ways of the selected set are compared at once, so a read or write that hits finishes in the same cycle it is presented.

On a miss the processor is held with a stall signal while the controller picks a victim way. An invalid way is taken first; otherwise the way the recency bit marks as least recently used is taken. A dirty victim is copied back to memory, and a clean one is simply dropped. The missing line is then fetched, and the request is served from the refilled line. Writes follow a write-back, write-allocate policy: a write hit changes only the cached line and marks it dirty, and a write miss first fetches the line and then merges the written word into it.

The processor keeps its request stable until `cpu_done` is seen high. The request is taken on that clock edge. Memory transfers use a request/ready handshake in which `mem_ready` completes one whole-line transfer.

Top module: `cache2w_top`

## Requirements
- R1: With default parameters the word select is address bits [3:2], the set index is bits [5:4] and the tag is bits [15:6]. Both ways of the indexed set are compared at once, and a hit raises `cpu_done` in the cycle the request is presented, with `cpu_stall` low.
- R2: On a read, `cpu_rdata` is the selected word of the way whose valid tag matched, or of the just-refilled line after a miss.
- R3: A write hit updates only the cached word, sets that way's dirty flag and starts no memory transfer. A later read returns the new word.
- R4: A miss raises `cpu_stall` until `cpu_done`. When the victim is clean, exactly one line read and no line write take place.
- R5: When the victim is valid and dirty, its full line is written to memory at line address {victim tag, set index} before the new line is read.
- R6: A write miss allocates. The line is read from memory, the written word replaces the selected word, the line becomes dirty, and the other words keep their memory values.
- R7: The victim is way 0 if it is invalid, else way 1 if it is invalid, else the least recently used way. Every hit and every refill marks the other way as the next to evict.
- R8: After reset all valid and dirty flags are clear, `cpu_stall`, `cpu_done` and `mem_req` are low, and the first access to any line misses.
- R9: A memory request keeps `mem_addr` and `mem_we` stable until `mem_ready`. `cpu_done` rises in the cycle after the refill's `mem_ready`, and the miss takes one cycle plus one or two memory transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address of a word |
| cpu_wdata | input | DATA_W | Write word |
| cpu_rdata | output | DATA_W | Read word, valid while `cpu_done` is high |
| cpu_done | output | 1 | Request completes on this clock edge |
| cpu_stall | output | 1 | Request pending and not completing |
| mem_req | output | 1 | Line transfer request |
| mem_we | output | 1 | 1 = line write-back, 0 = line read |
| mem_addr | output | ADDR_W-OFF_W | Line address {tag, index} |
| mem_wdata | output | LINE_W | Line written back |
| mem_rdata | input | LINE_W | Line returned with `mem_ready` |
| mem_ready | input | 1 | Completes the current line transfer |

## Verification
A hit is due in the same cycle as its request. A miss with a clean victim is due LAT+1 cycles later, where LAT is the bench memory's latency. A miss with a dirty victim is due 2·LAT+2 cycles later. The bench computes each expected wait from a model of tags, flags and recency bits, then samples `cpu_done` one time unit after every falling edge and counts the falling edges until it is seen. Line transfers are counted at the edge where the memory asserts `mem_ready`, so every access is checked for the exact number of reads and write-backs and for the exact data.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WBACK = 2'd1,
        ST_FILL  = 2'd2,
        ST_RESP  = 2'd3
    } ctl_state_e;

endpackage

// File: rtl/cache2w_way.sv
module cache2w_way #(
    parameter int SETS   = 4,
    parameter int TAG_W  = 10,
    parameter int LINE_W = 128,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line,
    input  logic              wr_dirty,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_line
);
    typedef struct packed {
        logic [SETS-1:0] vld;
        logic [SETS-1:0] drt;
    } meta_t;

    meta_t meta_d, meta_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [LINE_W-1:0] line_q [SETS];

    always_comb begin
        meta_d = meta_q;
        if (wr_en) begin
            meta_d.vld[idx] = 1'b1;
            meta_d.drt[idx] = wr_dirty;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) meta_q <= '0;
        else        meta_q <= meta_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[idx]  <= wr_tag;
            line_q[idx] <= wr_line;
        end
    end

    assign rd_valid = meta_q.vld[idx];
    assign rd_dirty = meta_q.drt[idx];
    assign rd_tag   = tag_q[idx];
    assign rd_line  = line_q[idx];
endmodule

// File: rtl/cache2w_recency.sv
module cache2w_recency #(
    parameter int SETS   = 4,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             upd_en,
    input  logic             used_way,
    output logic             evict_way
);
    logic [SETS-1:0] rec_d, rec_q;

    always_comb begin
        rec_d = rec_q;
        if (upd_en) rec_d[idx] = ~used_way;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rec_q <= '0;
        else        rec_q <= rec_d;
    end

    assign evict_way = rec_q[idx];
endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl
    import cache2w_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_req,
    input  logic       hit,
    input  logic       vict_way,
    input  logic       vict_wb,
    input  logic       mem_ready,
    output ctl_state_e state_o,
    output logic       way_o,
    output logic       done_o,
    output logic       hit_acc_o,
    output logic       fill_o,
    output logic       mem_req_o,
    output logic       mem_we_o
);
    typedef struct packed {
        ctl_state_e st;
        logic       way;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d     = ctl_q;
        done_o    = 1'b0;
        hit_acc_o = 1'b0;
        fill_o    = 1'b0;
        mem_req_o = 1'b0;
        mem_we_o  = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (hit) begin
                        done_o    = 1'b1;
                        hit_acc_o = 1'b1;
                    end else begin
                        ctl_d.way = vict_way;
                        ctl_d.st  = vict_wb ? ST_WBACK : ST_FILL;
                    end
                end
            end
            ST_WBACK: begin
                mem_req_o = 1'b1;
                mem_we_o  = 1'b1;
                if (mem_ready) ctl_d.st = ST_FILL;
            end
            ST_FILL: begin
                mem_req_o = 1'b1;
                if (mem_ready) begin
                    fill_o   = 1'b1;
                    ctl_d.st = ST_RESP;
                end
            end
            ST_RESP: begin
                done_o   = 1'b1;
                ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE, way: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign state_o = ctl_q.st;
    assign way_o   = ctl_q.way;
endmodule

// File: rtl/cache2w_top.sv
module cache2w_top
    import cache2w_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int SETS       = 4,
    localparam int WAYS      = 2,
    localparam int BYTE_W    = $clog2(DATA_W / 8),
    localparam int WSEL_W    = $clog2(LINE_WORDS),
    localparam int OFF_W     = BYTE_W + WSEL_W,
    localparam int IDX_W     = $clog2(SETS),
    localparam int TAG_W     = ADDR_W - OFF_W - IDX_W,
    localparam int LINE_W    = DATA_W * LINE_WORDS,
    localparam int LADDR_W   = ADDR_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               cpu_done,
    output logic               cpu_stall,
    output logic               mem_req,
    output logic               mem_we,
    output logic [LADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0]  mem_wdata,
    input  logic [LINE_W-1:0]  mem_rdata,
    input  logic               mem_ready
);
    logic [TAG_W-1:0]  a_tag;
    logic [IDX_W-1:0]  a_idx;
    logic [WSEL_W-1:0] a_wsel;
    logic              unused_bytes;

    assign a_tag        = cpu_addr[ADDR_W-1 -: TAG_W];
    assign a_idx        = cpu_addr[OFF_W +: IDX_W];
    assign a_wsel       = cpu_addr[BYTE_W +: WSEL_W];
    assign unused_bytes = ^cpu_addr[BYTE_W-1:0];

    logic [WAYS-1:0]   w_valid, w_dirty, w_match, w_wr;
    logic [TAG_W-1:0]  w_tag  [WAYS];
    logic [LINE_W-1:0] w_line [WAYS];
    logic [LINE_W-1:0] wr_line;
    logic              wr_dirty;

    ctl_state_e st;
    logic       way_q, hit, hit_way, hit_acc, fill;
    logic       rec_way, vict_way, vict_wb;

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        cache2w_way #(
            .SETS  (SETS),
            .TAG_W (TAG_W),
            .LINE_W(LINE_W)
        ) u_way (
            .clk     (clk),
            .rst_n   (rst_n),
            .idx     (a_idx),
            .wr_en   (w_wr[g]),
            .wr_tag  (a_tag),
            .wr_line (wr_line),
            .wr_dirty(wr_dirty),
            .rd_valid(w_valid[g]),
            .rd_dirty(w_dirty[g]),
            .rd_tag  (w_tag[g]),
            .rd_line (w_line[g])
        );
        assign w_match[g] = w_valid[g] && (w_tag[g] == a_tag);
        assign w_wr[g]    = (hit_acc && cpu_we && w_match[g])
                          || (fill && (way_q == 1'(g)));
    end

    assign hit     = |w_match;
    assign hit_way = w_match[1];

    always_comb begin
        if (!w_valid[0])      vict_way = 1'b0;
        else if (!w_valid[1]) vict_way = 1'b1;
        else                  vict_way = rec_way;
        vict_wb = w_valid[vict_way] && w_dirty[vict_way];
    end

    always_comb begin
        wr_line  = fill ? mem_rdata : w_line[hit_way];
        wr_dirty = fill ? cpu_we : 1'b1;
        if (cpu_we) wr_line[int'(a_wsel)*DATA_W +: DATA_W] = cpu_wdata;
    end

    cache2w_recency #(.SETS(SETS)) u_rec (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (a_idx),
        .upd_en   (hit_acc || fill),
        .used_way (fill ? way_q : hit_way),
        .evict_way(rec_way)
    );

    cache2w_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_req  (cpu_req),
        .hit      (hit),
        .vict_way (vict_way),
        .vict_wb  (vict_wb),
        .mem_ready(mem_ready),
        .state_o  (st),
        .way_o    (way_q),
        .done_o   (cpu_done),
        .hit_acc_o(hit_acc),
        .fill_o   (fill),
        .mem_req_o(mem_req),
        .mem_we_o (mem_we)
    );

    assign cpu_stall = cpu_req && !cpu_done;
    assign cpu_rdata = w_line[hit_way][int'(a_wsel)*DATA_W +: DATA_W];
    assign mem_addr  = (st == ST_WBACK) ? {w_tag[way_q], a_idx} : {a_tag, a_idx};
    assign mem_wdata = w_line[way_q];
endmodule

// File: rtl/cache2w_chk.sv
module cache2w_chk #(
    parameter int LADDR_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cpu_req,
    input logic               cpu_done,
    input logic               mem_req,
    input logic               mem_we,
    input logic               mem_ready,
    input logic [LADDR_W-1:0] mem_addr
);
    // R9: a pending transfer holds its address and direction
    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R5: a finished write-back is followed directly by the line read
    a_r5_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_ready |=> mem_req && !mem_we);

    // R9: completion one cycle after the refill is accepted
    a_r9_done_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && mem_ready |=> cpu_done);

    // R3: completion never overlaps a memory transfer
    a_r3_done_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> !mem_req);

    // R4: a held request that neither completes nor transfers starts a transfer
    a_r4_miss_starts_mem: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && !cpu_done && !mem_req |=> mem_req);
endmodule

bind cache2w_top cache2w_chk #(.LADDR_W(LADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_req  (cpu_req),
    .cpu_done (cpu_done),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_ready(mem_ready),
    .mem_addr (mem_addr)
);

// File: tb/sim_cache2w_top.sv
`timescale 1ns/1ps
module sim_cache2w_top;
    localparam int LAT    = 2;
    localparam int NTAG   = 8;
    localparam int NLINE  = NTAG * 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0]  cpu_addr = '0;
    logic [31:0]  cpu_wdata = '0;
    logic [31:0]  cpu_rdata;
    logic         cpu_done, cpu_stall;
    logic         mem_req, mem_we, mem_ready = 1'b0;
    logic [11:0]  mem_addr;
    logic [127:0] mem_wdata, mem_rdata = '0;

    always #4 clk = ~clk;

    cache2w_top u0 (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_done(cpu_done), .cpu_stall(cpu_stall), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    int n_chk = 0, n_fail = 0;
    int rd_cnt = 0, wb_cnt = 0, lat = 0;
    logic [127:0] mem  [NLINE];
    logic [127:0] gold [NLINE];
    int  m_tag [4][2];
    bit  m_val [4][2];
    bit  m_drt [4][2];
    bit  m_lru [4];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    // memory model: LAT falling edges after a request it completes a line transfer
    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready = 1'b0;
            lat = 0;
        end else if (mem_req) begin
            lat++;
            if (lat == LAT) begin
                mem_ready = 1'b1;
                if (mem_we) begin
                    wb_cnt++;
                    chk(mem_wdata == gold[mem_addr[4:0]], "R5", "written-back line",
                        longint'(mem_wdata[63:0]), longint'(gold[mem_addr[4:0]][63:0]));
                    mem[mem_addr[4:0]] = mem_wdata;
                end else begin
                    rd_cnt++;
                    mem_rdata = mem[mem_addr[4:0]];
                end
            end
        end
    end

    // one processor access; caller stands at a falling edge
    task automatic do_op(input bit we, input int tag, input int idx, input int w,
                         input logic [31:0] wd, input string req);
        int  line, waits, rd0, wb0, v, exp_waits;
        bit  hit, exp_wb;
        logic [31:0] rd;
        line = tag * 4 + idx;
        hit = 0; v = 0;
        for (int k = 0; k < 2; k++)
            if (m_val[idx][k] && m_tag[idx][k] == tag) begin hit = 1; v = k; end
        if (!hit) v = !m_val[idx][0] ? 0 : (!m_val[idx][1] ? 1 : int'(m_lru[idx]));
        exp_wb = !hit && m_val[idx][v] && m_drt[idx][v];
        exp_waits = hit ? 0 : (exp_wb ? 2 * LAT + 2 : LAT + 1);
        rd0 = rd_cnt; wb0 = wb_cnt;
        cpu_req = 1'b1; cpu_we = we; cpu_wdata = wd;
        cpu_addr = 16'((tag << 6) | (idx << 4) | (w << 2));
        waits = 0;
        #1;
        while (!cpu_done && waits < 100) begin
            chk(cpu_stall == 1'b1, "R4", "stall while pending", cpu_stall, 1);
            waits++;
            @(negedge clk); #1;
        end
        rd = cpu_rdata;
        chk(waits == exp_waits, req, "cycles to done (R9)", waits, exp_waits);
        chk(rd_cnt - rd0 == (hit ? 0 : 1), req, "line reads (R4)", rd_cnt - rd0, hit ? 0 : 1);
        chk(wb_cnt - wb0 == (exp_wb ? 1 : 0), req, "write-backs (R5)", wb_cnt - wb0, exp_wb ? 1 : 0);
        if (!we) chk(rd == gold[line][w*32 +: 32], req, "read word (R2)",
                     rd, gold[line][w*32 +: 32]);
        // update model
        m_tag[idx][v] = tag; m_val[idx][v] = 1;
        m_drt[idx][v] = (hit ? m_drt[idx][v] : 1'b0) | we;
        m_lru[idx] = (v == 0);
        if (we) gold[line][w*32 +: 32] = wd;
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        chk(0, "ALL", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int seed;
        for (int l = 0; l < NLINE; l++)
            for (int w = 0; w < 4; w++) begin
                mem[l][w*32 +: 32]  = {8'hC3, 8'(l), 8'(w), 8'h5A};
                gold[l][w*32 +: 32] = {8'hC3, 8'(l), 8'(w), 8'h5A};
            end
        for (int s = 0; s < 4; s++) begin
            m_lru[s] = 0;
            for (int k = 0; k < 2; k++) begin m_val[s][k] = 0; m_drt[s][k] = 0; m_tag[s][k] = 0; end
        end
        repeat (3) @(negedge clk);
        // R8: reset state at the ports
        chk(cpu_stall == 0, "R8", "stall after reset", cpu_stall, 0);
        chk(mem_req == 0, "R8", "mem_req after reset", mem_req, 0);
        chk(cpu_done == 0, "R8", "done after reset", cpu_done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R8/R1: first touches miss, repeats hit
        for (int s = 0; s < 4; s++) do_op(0, 1, s, s, 0, "R8");
        for (int s = 0; s < 4; s++) do_op(0, 1, s, 3 - s, 0, "R1");
        // R7: second tag fills the invalid way, then recency picks the victim
        do_op(0, 2, 0, 0, 0, "R7");
        do_op(0, 1, 0, 1, 0, "R7");
        do_op(0, 3, 0, 2, 0, "R7");
        do_op(0, 1, 0, 2, 0, "R7");
        do_op(0, 2, 0, 0, 0, "R7");
        // R3: write hit stays in cache, read back
        do_op(1, 1, 1, 2, 32'hDEAD_BEEF, "R3");
        do_op(0, 1, 1, 2, 0, "R3");
        // R5: force eviction of the dirty line
        do_op(0, 4, 1, 0, 0, "R5");
        do_op(0, 5, 1, 0, 0, "R5");
        do_op(0, 1, 1, 2, 0, "R5");
        // R6: write miss allocates and merges
        do_op(1, 6, 2, 1, 32'h1234_5678, "R6");
        for (int w = 0; w < 4; w++) do_op(0, 6, 2, w, 0, "R6");
        // R2: sweep of every line and word
        for (int t = 0; t < NTAG; t++)
            for (int s = 0; s < 4; s++)
                for (int w = 0; w < 4; w++) do_op(0, t, s, w, 0, "R2");
        // mixed traffic
        seed = 32'h1ACE;
        for (int i = 0; i < 1500; i++) begin
            seed = seed * 1103515245 + 12345;
            do_op(seed[20], (seed >> 8) & 7, (seed >> 12) & 3, (seed >> 16) & 3,
                  32'(seed) ^ 32'h5555_0000, "R6");
        end
        finish_run();
    end
endmodule